// File: doc/BRIEF.md
# Coprocessor Access Trap Decoder

This block decides, in the same cycle, whether a decoded coprocessor register move must be diverted to the hypervisor privilege level. A decode stage presents the privilege level (0 to 3), the security state, the transfer kind, and the coproc, CRn and CRm fields of the move. It also presents a 16-bit trap mask held by the hypervisor and a flag that says whether the move would already be undefined if the selected mask bit were clear. The block returns a trap flag and a six-bit exception class code.

Only moves to coprocessor 15 can be trapped. The mask bit that applies is chosen by the register field that names the register for that transfer kind. A single-word move uses CRn and a two-word move uses CRm. Two mask positions are reserved and can never cause a trap. Kernel-level non-secure moves trap whenever the selected bit is set. User-level non-secure moves trap only when the move would otherwise be legal, so an undefined user access stays undefined. The block has no state and no clock.

Top module: `cp_trap_decoder`

## Requirements
- R1: A move whose coproc field is not 4'b1111 never traps, whatever the mask holds; trap_o is 0 and class_o is 0.
- R2: For a single-word move (two_word_i = 0) the mask bit index is the CRn field, and CRm has no effect on the decision.
- R3: For a two-word move (two_word_i = 1) the mask bit index is the CRm field, and CRn has no effect on the decision.
- R4: Mask bits 4 and 14 never cause a trap, even when they are presented as 1.
- R5: A non-secure (nonsecure_i = 1) move from level 1 (el_i = 2'd1) to coprocessor 15 traps exactly when the selected mask bit is 1. The undefined flag has no effect at this level.
- R6: A non-secure move from level 0 (el_i = 2'd0) traps only when the selected mask bit is 1 and undef_if_clear_i is 0. It does not trap when undef_if_clear_i is 1.
- R7: Moves from level 2 or 3, and all secure moves (nonsecure_i = 0), never trap.
- R8: When trap_o is 1, class_o equals 6'h03.
- R9: When trap_o is 0, class_o equals 6'h00.
- R10: The outputs depend only on the present inputs and follow an input change within the same clock cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| el_i | input | 2 | Current privilege level, 0 to 3 |
| nonsecure_i | input | 1 | 1 when the move is made in the non-secure state |
| two_word_i | input | 1 | 1 for a two-word transfer, 0 for a single-word transfer |
| coproc_i | input | 4 | Coprocessor number field of the move |
| crn_i | input | 4 | CRn field of the move |
| crm_i | input | 4 | CRm field of the move |
| trap_mask_i | input | 16 | Hypervisor trap mask, one bit per register index |
| undef_if_clear_i | input | 1 | The move would be undefined with the selected mask bit at 0 |
| trap_o | output | 1 | The move must be taken to the hypervisor level |
| class_o | output | 6 | Exception class code, 0x03 when trapping, otherwise 0 |

## Verification
Immediate assertions check on every evaluation the properties that follow from the inputs alone. A foreign coprocessor, a secure move, a level above 1, or a reserved index never produces a trap. The class code always agrees with the trap flag, and a user-level move flagged undefined is never trapped. Only the bench scenarios can show that the right field selects the mask bit and that a set bit at a legal index actually produces a trap. The bench shows this by setting single mask bits and making CRn and CRm disagree. It also changes the inputs within one cycle to show that the outputs follow without delay.

// File: rtl/cp_trap_pkg.sv
package cp_trap_pkg;

  localparam int unsigned MASK_W  = 16;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned EC_W    = 6;
  localparam int unsigned LVL_W   = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } priv_lvl_e;

  typedef enum logic {
    XFER_SINGLE = 1'b0,
    XFER_DOUBLE = 1'b1
  } xfer_kind_e;

  typedef struct packed {
    logic               hit;
    logic [FIELD_W-1:0] idx;
  } mask_sel_t;

endpackage

// File: rtl/cp_trap_index_sel.sv
module cp_trap_index_sel
  import cp_trap_pkg::*;
#(
  parameter logic [FIELD_W-1:0] CP_TRAPPABLE = 4'hF
) (
  input  logic               two_word_i,
  input  logic [FIELD_W-1:0] coproc_i,
  input  logic [FIELD_W-1:0] crn_i,
  input  logic [FIELD_W-1:0] crm_i,
  output mask_sel_t          sel_o
);

  xfer_kind_e kind;

  always_comb begin
    kind      = xfer_kind_e'(two_word_i);
    sel_o.hit = (coproc_i == CP_TRAPPABLE);
    unique case (kind)
      XFER_SINGLE: sel_o.idx = crn_i;
      XFER_DOUBLE: sel_o.idx = crm_i;
      default:     sel_o.idx = crn_i;
    endcase
  end

endmodule

// File: rtl/cp_trap_mask_filter.sv
module cp_trap_mask_filter
  import cp_trap_pkg::*;
#(
  parameter int unsigned          W        = MASK_W,
  parameter logic [MASK_W-1:0]    RSVD_MAP = 16'h4010
) (
  input  logic [W-1:0]       mask_i,
  input  mask_sel_t          sel_i,
  output logic               bit_o
);

  logic [W-1:0] mask_eff;

  for (genvar g = 0; g < W; g++) begin : g_bit
    if (RSVD_MAP[g]) begin : g_rsvd
      assign mask_eff[g] = 1'b0;
    end else begin : g_live
      assign mask_eff[g] = mask_i[g];
    end
  end

  assign bit_o = sel_i.hit & mask_eff[sel_i.idx];

  always_comb begin
    if (RSVD_MAP[sel_i.idx])
      AST_RSVD_NEVER_SET: assert (!bit_o) else $error("reserved index selected"); // R4
  end

endmodule

// File: rtl/cp_trap_policy.sv
module cp_trap_policy
  import cp_trap_pkg::*;
#(
  parameter logic [EC_W-1:0] TRAP_EC = 6'h03
) (
  input  logic [LVL_W-1:0] el_i,
  input  logic             nonsecure_i,
  input  logic             bit_i,
  input  logic             undef_if_clear_i,
  output logic             trap_o,
  output logic [EC_W-1:0]  class_o
);

  priv_lvl_e lvl;
  logic      eligible;

  always_comb begin
    lvl = priv_lvl_e'(el_i);
    unique case (lvl)
      LVL_KERNEL: eligible = nonsecure_i;
      LVL_USER:   eligible = nonsecure_i & ~undef_if_clear_i;
      default:    eligible = 1'b0;
    endcase
    trap_o  = eligible & bit_i;
    class_o = trap_o ? TRAP_EC : '0;
  end

  always_comb begin
    if (!bit_i)
      AST_NO_BIT_NO_TRAP: assert (!trap_o) else $error("trap without mask bit"); // R5
  end

endmodule

// File: rtl/cp_trap_decoder.sv
module cp_trap_decoder
  import cp_trap_pkg::*;
#(
  parameter logic [FIELD_W-1:0] CP_TRAPPABLE = 4'hF,
  parameter logic [MASK_W-1:0]  RSVD_MAP     = 16'h4010,
  parameter logic [EC_W-1:0]    TRAP_EC      = 6'h03
) (
  input  logic [LVL_W-1:0]   el_i,
  input  logic               nonsecure_i,
  input  logic               two_word_i,
  input  logic [FIELD_W-1:0] coproc_i,
  input  logic [FIELD_W-1:0] crn_i,
  input  logic [FIELD_W-1:0] crm_i,
  input  logic [MASK_W-1:0]  trap_mask_i,
  input  logic               undef_if_clear_i,
  output logic               trap_o,
  output logic [EC_W-1:0]    class_o
);

  mask_sel_t sel;
  logic      mask_bit;

  cp_trap_index_sel #(
    .CP_TRAPPABLE (CP_TRAPPABLE)
  ) u_sel (
    .two_word_i (two_word_i),
    .coproc_i   (coproc_i),
    .crn_i      (crn_i),
    .crm_i      (crm_i),
    .sel_o      (sel)
  );

  cp_trap_mask_filter #(
    .W        (MASK_W),
    .RSVD_MAP (RSVD_MAP)
  ) u_filter (
    .mask_i (trap_mask_i),
    .sel_i  (sel),
    .bit_o  (mask_bit)
  );

  cp_trap_policy #(
    .TRAP_EC (TRAP_EC)
  ) u_policy (
    .el_i             (el_i),
    .nonsecure_i      (nonsecure_i),
    .bit_i            (mask_bit),
    .undef_if_clear_i (undef_if_clear_i),
    .trap_o           (trap_o),
    .class_o          (class_o)
  );

  always_comb begin
    if (coproc_i != CP_TRAPPABLE)
      AST_FOREIGN_CP_QUIET: assert (!trap_o) else $error("foreign coproc trapped"); // R1
    if (!nonsecure_i || el_i[1])
      AST_HIGH_OR_SECURE_QUIET: assert (!trap_o) else $error("privileged/secure trapped"); // R7
    if (el_i == 2'd0 && undef_if_clear_i)
      AST_USER_UNDEF_STAYS: assert (!trap_o) else $error("undefined user move trapped"); // R6
    if (trap_o)
      AST_TRAP_CLASS: assert (class_o == TRAP_EC) else $error("wrong class on trap"); // R8
    else
      AST_IDLE_CLASS_ZERO: assert (class_o == '0) else $error("class without trap"); // R9
  end

endmodule

// File: tb/cp_trap_decoder_tb.sv
module cp_trap_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  el;
  logic        ns;
  logic        tw;
  logic [3:0]  cp;
  logic [3:0]  crn;
  logic [3:0]  crm;
  logic [15:0] mask;
  logic        undef;
  logic        trap;
  logic [5:0]  cls;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cp_trap_decoder u_dut (
    .el_i             (el),
    .nonsecure_i      (ns),
    .two_word_i       (tw),
    .coproc_i         (cp),
    .crn_i            (crn),
    .crm_i            (crm),
    .trap_mask_i      (mask),
    .undef_if_clear_i (undef),
    .trap_o           (trap),
    .class_o          (cls)
  );

  function automatic bit model_trap();
    int idx;
    if (cp !== 4'hF) return 1'b0;
    if (ns !== 1'b1) return 1'b0;
    idx = tw ? int'(crm) : int'(crn);
    if (idx == 4 || idx == 14) return 1'b0;
    if (mask[idx] !== 1'b1) return 1'b0;
    if (el == 2'd1) return 1'b1;
    if (el == 2'd0) return !undef;
    return 1'b0;
  endfunction

  task automatic check(input string tag);
    bit       exp_t;
    bit [5:0] exp_c;
    exp_t = model_trap();
    exp_c = exp_t ? 6'h03 : 6'h00;
    n_chk++;
    if (trap !== exp_t || cls !== exp_c) begin
      n_bad++;
      $display("FAIL %s (class per R8/R9): trap=%0b class=%0h expected trap=%0b class=%0h",
               tag, trap, cls, exp_t, exp_c);
    end
  endtask

  task automatic drive(input logic [1:0] e, input logic s, input logic w,
                       input logic [3:0] c, input logic [3:0] n, input logic [3:0] m,
                       input logic [15:0] k, input logic u);
    el = e; ns = s; tw = w; cp = c; crn = n; crm = m; mask = k; undef = u;
  endtask

  task automatic step(input string tag);
    @(posedge clk); #1;
    @(negedge clk);
    check(tag);
  endtask

  function automatic string sweep_tag(int e, int s, int i);
    if (e >= 2 || s == 0) return "R7";
    if (i == 4 || i == 14) return "R4";
    if (e == 1) return "R5";
    return "R6";
  endfunction

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    drive(2'd0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 16'h0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset R9");
    rst_n = 1'b1;

    // R1: foreign coprocessor with full mask
    drive(2'd1, 1'b1, 1'b0, 4'hE, 4'd7, 4'd7, 16'hFFFF, 1'b0); step("R1");
    drive(2'd1, 1'b1, 1'b1, 4'h0, 4'd7, 4'd7, 16'hFFFF, 1'b0); step("R1");
    // R2: single-word uses CRn
    drive(2'd1, 1'b1, 1'b0, 4'hF, 4'd7, 4'd3, 16'h0080, 1'b0); step("R2");
    drive(2'd1, 1'b1, 1'b0, 4'hF, 4'd3, 4'd7, 16'h0080, 1'b0); step("R2");
    // R3: two-word uses CRm
    drive(2'd1, 1'b1, 1'b1, 4'hF, 4'd3, 4'd7, 16'h0080, 1'b0); step("R3");
    drive(2'd1, 1'b1, 1'b1, 4'hF, 4'd7, 4'd3, 16'h0080, 1'b0); step("R3");
    // R4: reserved bits
    drive(2'd1, 1'b1, 1'b0, 4'hF, 4'd4, 4'd0, 16'h4010, 1'b0); step("R4");
    drive(2'd1, 1'b1, 1'b1, 4'hF, 4'd0, 4'd14, 16'hFFFF, 1'b0); step("R4");
    // R6: user level, legal vs undefined
    drive(2'd0, 1'b1, 1'b0, 4'hF, 4'd9, 4'd0, 16'h0200, 1'b0); step("R6");
    drive(2'd0, 1'b1, 1'b0, 4'hF, 4'd9, 4'd0, 16'h0200, 1'b1); step("R6");
    // R5: kernel ignores undefined flag
    drive(2'd1, 1'b1, 1'b0, 4'hF, 4'd9, 4'd0, 16'h0200, 1'b1); step("R5 R8");
    // R7: secure and high levels
    drive(2'd1, 1'b0, 1'b0, 4'hF, 4'd9, 4'd0, 16'hFFFF, 1'b0); step("R7");
    drive(2'd2, 1'b1, 1'b0, 4'hF, 4'd9, 4'd0, 16'hFFFF, 1'b0); step("R7");
    drive(2'd3, 1'b1, 1'b1, 4'hF, 4'd0, 4'd9, 16'hFFFF, 1'b0); step("R7");

    // R10: outputs follow a mid-cycle change without a clock edge
    @(posedge clk); #0.5;
    drive(2'd1, 1'b1, 1'b0, 4'hF, 4'd2, 4'd0, 16'h0004, 1'b0);
    #0.5; check("R10");
    mask = 16'h0000;
    #0.5; check("R10");

    // Exhaustive sweep of level, security, kind, flag, index with full mask
    for (int e = 0; e < 4; e++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 2; w++)
          for (int u = 0; u < 2; u++)
            for (int i = 0; i < 16; i++) begin
              if (w == 1)
                drive(2'(e), 1'(s), 1'b1, 4'hF, 4'(15 - i), 4'(i), 16'hFFFF, 1'(u));
              else
                drive(2'(e), 1'(s), 1'b0, 4'hF, 4'(i), 4'(15 - i), 16'hFFFF, 1'(u));
              step(sweep_tag(e, s, i));
            end

    // Pseudo-random mix compared on every clock
    for (int r = 0; r < 3000; r++) begin
      drive(2'($urandom), 1'($urandom), 1'($urandom),
            ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF,
            4'($urandom), 4'($urandom), 16'($urandom), 1'($urandom));
      step("R2 R3 R5 R6 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule